// File: doc/BRIEF.md
# Three-Level Page Table Walker

The walker translates one virtual page number at a time into a physical page address by reading page table entries from memory, starting at a root table and descending up to three levels. Each entry it fetches is judged against the request: the access kind (load, store, fetch), the privilege of the requester (user or supervisor), the supervisor-may-touch-user-pages control and the make-executable-readable control. A leaf that passes yields a physical address plus read/write/execute permissions. Any entry that fails produces a fault result.

When a passing leaf still needs its Accessed bit set, or its Dirty bit set on a store, the walker writes the updated entry back with a locked compare-and-swap transaction on the same memory port. The memory answers with the value it held. If that value differs from what the walker read, another agent changed the entry, and the walk starts again from the root. If the memory reports the location as not writable, or reports an access error on any transaction, the translation faults.

A requester hands over a request with a valid/ready handshake and takes the result with a second handshake. No new request is accepted until the current result has been taken.

Top module: `tbl_walker`

## Requirements
- R1: After reset, `req_ready` is 1 while `res_valid` and `mem_req_valid` are 0.
- R2: Entry bit layout: valid bit 0, read bit 1, write bit 2, execute bit 3, user bit 4, accessed bit 6, dirty bit 7, page number bits 53:10. The walk reads the level-2 entry first, at `root_ppn*4096 + vpn[26:18]*8`. An entry that is valid with read, write and execute all clear points to the next table. The next table's base is its page number times 4096, and it is indexed by `vpn[17:9]`, then by `vpn[8:0]`. A memory request that is not accepted holds its address.
- R3: A walk faults on an entry whose valid bit is 0, on a leaf with write set and read clear (write alone, or write with execute), and on a pointer entry found at level 0.
- R4: `req_smode`=1 means supervisor and 0 means user. A leaf with the user bit set faults for a supervisor request when `req_sum` is 0 or the access is a fetch. A leaf with the user bit clear faults for a user request.
- R5: A leaf at level 2 whose page number has any of its low 18 bits set faults, and so does a leaf at level 1 whose page number has any of its low 9 bits set.
- R6: `req_acc` is 0 for load, 1 for store and 2 for fetch. A load needs read, or execute together with `req_mxr`. A store needs write. A fetch needs execute.
- R7: On success, `res_paddr` = (page number OR (vpn AND low-bit mask of the leaf's level)) × 4096. `res_perm_r` = read OR (execute AND mxr). `res_perm_x` = execute. `res_perm_w` = write AND (store OR dirty).
- R8: The updated entry is the read entry OR accessed, OR dirty on a store. If it differs from the read entry, one compare-and-swap is issued with `mem_req_cmp` = the read entry and `mem_req_wdata` = the updated entry. If it does not differ, no compare-and-swap is issued.
- R9: If the compare-and-swap returns a value different from the read entry, the walk restarts from the root.
- R10: A response with `mem_rsp_err` set faults the walk. A compare-and-swap response with `mem_rsp_nowr` set faults the walk, and memory is left unchanged.
- R11: `req_ready` stays 0 from acceptance until the result is taken. The result holds stable while `res_valid`=1 and `res_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_vpn | input | 27 | Virtual page number |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_smode | input | 1 | 1 supervisor, 0 user |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Execute-only pages readable by loads |
| root_ppn | input | 44 | Page number of the root table |
| mem_req_valid | output | 1 | Memory transaction request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 56 | Entry byte address |
| mem_req_cas | output | 1 | 1 locked compare-and-swap, 0 read |
| mem_req_cmp | output | 64 | Compare value for the swap |
| mem_req_wdata | output | 64 | Value written when the compare matches |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_data | input | 64 | Entry read, or value held before the swap |
| mem_rsp_err | input | 1 | Access error |
| mem_rsp_nowr | input | 1 | Location cannot be written |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Requester takes the result |
| res_fault | output | 1 | Translation failed |
| res_paddr | output | 56 | Physical page address |
| res_perm_r | output | 1 | Read allowed |
| res_perm_w | output | 1 | Write allowed |
| res_perm_x | output | 1 | Execute allowed |

## Verification
Every memory transaction takes one cycle to be offered and at least one more for its response. The result registers on the same edge that captures the deciding response. `res_valid` is therefore due one edge after the last response, and the bench samples it at the following falling edge. The bench model of memory registers each accepted transaction and answers it exactly one cycle later, with `mem_req_ready` withheld on a fixed cycle pattern. The bench counts reads and compare-and-swaps per walk and compares them with the number the rules predict, so an extra or missing level shows up even when the final result happens to match. The result-hold and ready checks sample across several falling edges with `res_ready` held low before the result is taken.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int PTE_W    = 64;
    localparam int PG_SHIFT = 12;
    localparam int PPN_LSB  = 10;

    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;
    localparam int BIT_U = 4;
    localparam int BIT_A = 6;
    localparam int BIT_D = 7;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        VD_FAULT = 2'd0,
        VD_NEXT  = 2'd1,
        VD_LEAF  = 2'd2
    } verdict_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RD   = 3'd1,
        S_RDW  = 3'd2,
        S_CAS  = 3'd3,
        S_CASW = 3'd4,
        S_DONE = 3'd5
    } walk_st_e;
endpackage

// File: rtl/walk_addr.sv
module walk_addr
    import walk_pkg::*;
#(
    parameter int LEVELS = 3,
    parameter int IDX_W  = 9,
    parameter int PPN_W  = 44,
    parameter int LVL_W  = 2,
    parameter int VPN_W  = LEVELS * IDX_W,
    parameter int PA_W   = PPN_W + PG_SHIFT
) (
    input  logic [PPN_W-1:0] base_ppn,
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] lvl,
    input  logic [PPN_W-1:0] leaf_ppn,
    output logic [PA_W-1:0]  pte_addr,
    output logic [PA_W-1:0]  leaf_paddr,
    output logic [PPN_W-1:0] sp_mask
);
    localparam int OFS_W = IDX_W + 3;

    logic [IDX_W-1:0] idx_lv  [LEVELS];
    logic [PPN_W-1:0] mask_lv [LEVELS];
    logic [IDX_W-1:0] idx;
    logic [PPN_W-1:0] vpn_ext;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lv
        assign idx_lv[g]  = vpn[g*IDX_W +: IDX_W];
        assign mask_lv[g] = (PPN_W'(1) << (g * IDX_W)) - PPN_W'(1);
    end

    always_comb begin
        idx     = '0;
        sp_mask = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) begin
                idx     = idx_lv[i];
                sp_mask = mask_lv[i];
            end
        end
    end

    assign vpn_ext    = PPN_W'(vpn);
    assign pte_addr   = {base_ppn, {PG_SHIFT{1'b0}}} + PA_W'({idx, 3'b000});
    assign leaf_paddr = {leaf_ppn | (vpn_ext & sp_mask), {PG_SHIFT{1'b0}}};

    logic [OFS_W-1:0] unused_ofs;
    assign unused_ofs = '0;
endmodule

// File: rtl/pte_judge.sv
module pte_judge
    import walk_pkg::*;
#(
    parameter int PPN_W = 44
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [PPN_W-1:0] sp_mask,
    input  acc_e             acc,
    input  logic             smode,
    input  logic             sum,
    input  logic             mxr,
    output verdict_e         verdict,
    output logic [PPN_W-1:0] ppn,
    output logic             perm_r,
    output logic             perm_w,
    output logic             perm_x,
    output logic [PTE_W-1:0] pte_new
);
    logic f_v, f_r, f_w, f_x, f_u, f_d;
    logic is_store, is_fetch, is_load;

    assign f_v = pte[BIT_V];
    assign f_r = pte[BIT_R];
    assign f_w = pte[BIT_W];
    assign f_x = pte[BIT_X];
    assign f_u = pte[BIT_U];
    assign f_d = pte[BIT_D];
    assign ppn = pte[PPN_LSB +: PPN_W];

    assign is_store = (acc == ACC_STORE);
    assign is_fetch = (acc == ACC_FETCH);
    assign is_load  = !is_store && !is_fetch;

    always_comb begin
        if (!f_v)                                       verdict = VD_FAULT;
        else if (!(f_r || f_w || f_x))                  verdict = VD_NEXT;
        else if (f_w && !f_r)                           verdict = VD_FAULT;
        else if (f_u && smode && (!sum || is_fetch))    verdict = VD_FAULT;
        else if (!f_u && !smode)                        verdict = VD_FAULT;
        else if ((ppn & sp_mask) != '0)                 verdict = VD_FAULT;
        else if (is_load && !(f_r || (f_x && mxr)))     verdict = VD_FAULT;
        else if (is_store && !f_w)                      verdict = VD_FAULT;
        else if (is_fetch && !f_x)                      verdict = VD_FAULT;
        else                                            verdict = VD_LEAF;
    end

    assign perm_r  = f_r || (f_x && mxr);
    assign perm_x  = f_x;
    assign perm_w  = f_w && (is_store || f_d);
    assign pte_new = pte | (PTE_W'(1) << BIT_A) | (is_store ? (PTE_W'(1) << BIT_D) : '0);
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
    import walk_pkg::*;
#(
    parameter int LEVELS = 3,
    parameter int IDX_W  = 9,
    parameter int PPN_W  = 44,
    localparam int VPN_W = LEVELS * IDX_W,
    localparam int PA_W  = PPN_W + PG_SHIFT,
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [1:0]       req_acc,
    input  logic             req_smode,
    input  logic             req_sum,
    input  logic             req_mxr,
    input  logic [PPN_W-1:0] root_ppn,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic             mem_req_cas,
    output logic [PTE_W-1:0] mem_req_cmp,
    output logic [PTE_W-1:0] mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    input  logic             mem_rsp_err,
    input  logic             mem_rsp_nowr,
    output logic             res_valid,
    input  logic             res_ready,
    output logic             res_fault,
    output logic [PA_W-1:0]  res_paddr,
    output logic             res_perm_r,
    output logic             res_perm_w,
    output logic             res_perm_x
);
    typedef struct packed {
        walk_st_e         st;
        logic [LVL_W-1:0] lvl;
        logic [PPN_W-1:0] base;
        logic [PPN_W-1:0] root;
        logic [VPN_W-1:0] vpn;
        acc_e             acc;
        logic             smode;
        logic             sum;
        logic             mxr;
        logic [PTE_W-1:0] pte;
        logic [PTE_W-1:0] newp;
        logic             fault;
        logic [PA_W-1:0]  pa;
        logic             pr;
        logic             pw;
        logic             px;
    } wstate_t;

    wstate_t q, d;

    logic [PA_W-1:0]  pte_addr, leaf_pa;
    logic [PPN_W-1:0] sp_mask, j_ppn;
    verdict_e         j_verdict;
    logic             j_r, j_w, j_x;
    logic [PTE_W-1:0] j_new;

    walk_addr #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .LVL_W(LVL_W)
    ) u_addr (
        .base_ppn  (q.base),
        .vpn       (q.vpn),
        .lvl       (q.lvl),
        .leaf_ppn  (j_ppn),
        .pte_addr  (pte_addr),
        .leaf_paddr(leaf_pa),
        .sp_mask   (sp_mask)
    );

    pte_judge #(.PPN_W(PPN_W)) u_judge (
        .pte    (mem_rsp_data),
        .sp_mask(sp_mask),
        .acc    (q.acc),
        .smode  (q.smode),
        .sum    (q.sum),
        .mxr    (q.mxr),
        .verdict(j_verdict),
        .ppn    (j_ppn),
        .perm_r (j_r),
        .perm_w (j_w),
        .perm_x (j_x),
        .pte_new(j_new)
    );

    always_comb begin
        d             = q;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_cas   = 1'b0;
        case (q.st)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    d.st    = S_RD;
                    d.lvl   = LVL_W'(LEVELS - 1);
                    d.base  = root_ppn;
                    d.root  = root_ppn;
                    d.vpn   = req_vpn;
                    d.acc   = acc_e'(req_acc);
                    d.smode = req_smode;
                    d.sum   = req_sum;
                    d.mxr   = req_mxr;
                end
            end
            S_RD: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) d.st = S_RDW;
            end
            S_RDW: begin
                if (mem_rsp_valid) begin
                    d.st    = S_DONE;
                    d.fault = 1'b1;
                    d.pa    = '0;
                    {d.pr, d.pw, d.px} = 3'b000;
                    if (!mem_rsp_err) begin
                        if (j_verdict == VD_NEXT && q.lvl != '0) begin
                            d.st    = S_RD;
                            d.fault = 1'b0;
                            d.base  = j_ppn;
                            d.lvl   = q.lvl - 1'b1;
                        end else if (j_verdict == VD_LEAF) begin
                            d.fault = 1'b0;
                            d.pa    = leaf_pa;
                            {d.pr, d.pw, d.px} = {j_r, j_w, j_x};
                            d.pte   = mem_rsp_data;
                            d.newp  = j_new;
                            if (j_new != mem_rsp_data) d.st = S_CAS;
                        end
                    end
                end
            end
            S_CAS: begin
                mem_req_valid = 1'b1;
                mem_req_cas   = 1'b1;
                if (mem_req_ready) d.st = S_CASW;
            end
            S_CASW: begin
                if (mem_rsp_valid) begin
                    d.st = S_DONE;
                    if (mem_rsp_err || mem_rsp_nowr) begin
                        d.fault = 1'b1;
                        d.pa    = '0;
                        {d.pr, d.pw, d.px} = 3'b000;
                    end else if (mem_rsp_data != q.pte) begin
                        d.st   = S_RD;
                        d.lvl  = LVL_W'(LEVELS - 1);
                        d.base = q.root;
                    end
                end
            end
            S_DONE: begin
                if (res_ready) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req_addr  = pte_addr;
    assign mem_req_cmp   = q.pte;
    assign mem_req_wdata = q.newp;
    assign res_valid     = (q.st == S_DONE);
    assign res_fault     = q.fault;
    assign res_paddr     = q.pa;
    assign res_perm_r    = q.pr;
    assign res_perm_w    = q.pw;
    assign res_perm_x    = q.px;

    // R11: result held until taken
    p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_paddr) && $stable(res_fault)
            && $stable(res_perm_w));

    // R2: an unaccepted memory request keeps its address
    p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R8: the swap only adds accessed/dirty bits
    p_cas_ad_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_cas |->
            (((mem_req_wdata ^ mem_req_cmp) & ~PTE_W'(8'hC0)) == '0) &&
            ((mem_req_wdata & ~mem_req_cmp) != '0) && ((mem_req_cmp & ~mem_req_wdata) == '0));

    // R3: write-only and write+execute leaves never succeed, so write implies read
    p_write_has_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_fault && res_perm_w |-> res_perm_r);

    // R6: a successful fetch always grants execute
    p_fetch_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_fault && q.acc == ACC_FETCH |-> res_perm_x);
endmodule

// File: tb/tbl_walker_test.sv
module tbl_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [26:0] req_vpn = '0;
    logic [1:0]  req_acc = '0;
    logic        req_smode = 1'b0, req_sum = 1'b0, req_mxr = 1'b0;
    logic [43:0] root_ppn = 44'd1;
    logic        mem_req_valid, mem_req_cas;
    logic        mem_req_ready = 1'b0;
    logic [55:0] mem_req_addr;
    logic [63:0] mem_req_cmp, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0, mem_rsp_nowr = 1'b0;
    logic        res_valid, res_fault, res_perm_r, res_perm_w, res_perm_x;
    logic        res_ready = 1'b0;
    logic [55:0] res_paddr;

    tbl_walker uut (.*);

    always #10 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0;
    int rd_cnt, cas_cnt;
    bit rsp_due = 0, interfere = 0;
    logic [63:0] rsp_d;
    bit rsp_e, rsp_n;
    logic [63:0] mem [0:4095];

    logic        g_fault, g_r, g_w, g_x, g_to;
    logic [55:0] g_pa;

    localparam logic [26:0] VPN = {9'd3, 9'd5, 9'd7};

    function automatic int widx(input int ppn, input int idx);
        return ppn * 512 + idx;
    endfunction

    function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [7:0] fl);
        return ({20'd0, ppn} << 10) | {56'd0, fl};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // memory model: request seen at a falling edge with ready set is accepted
    // at the next rising edge and answered at the falling edge after it
    initial forever begin
        @(negedge clk);
        cyc++;
        mem_rsp_valid = 1'b0;
        if (rsp_due) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rsp_d;
            mem_rsp_err   = rsp_e;
            mem_rsp_nowr  = rsp_n;
            rsp_due = 0;
        end
        mem_req_ready = (cyc % 4) != 2;
        if (mem_req_valid && mem_req_ready) begin
            rsp_due = 1;
            rsp_e   = mem_req_addr >= 56'd32768;
            rsp_n   = mem_req_addr[14:12] == 3'd7;
            rsp_d   = '0;
            if (!rsp_e) begin
                if (mem_req_cas) begin
                    cas_cnt++;
                    if (interfere) begin
                        mem[mem_req_addr[14:3]] |= 64'h20;
                        interfere = 0;
                    end
                    rsp_d = mem[mem_req_addr[14:3]];
                    if (rsp_d == mem_req_cmp && !rsp_n) mem[mem_req_addr[14:3]] = mem_req_wdata;
                end else begin
                    rd_cnt++;
                    rsp_d = mem[mem_req_addr[14:3]];
                end
            end else if (!mem_req_cas) rd_cnt++;
            else cas_cnt++;
        end
    end

    initial begin
        #4_000_000;
        nfail++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    task automatic tables();
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        mem[widx(1, 3)] = mk(44'd2, 8'h01);
        mem[widx(2, 5)] = mk(44'd3, 8'h01);
    endtask

    task automatic walk(input logic [1:0] acc, input bit sm, input bit sum, input bit mxr, input bit hold);
        int t;
        @(negedge clk);
        rd_cnt = 0; cas_cnt = 0; g_to = 0;
        req_vpn = VPN; req_acc = acc; req_smode = sm; req_sum = sum; req_mxr = mxr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!res_valid && t < 200) begin
            @(negedge clk);
            t++;
            if (!res_valid) chk(req_ready == 1'b0, "R11 busy", req_ready, 0);
        end
        if (!res_valid) begin
            g_to = 1;
            chk(0, "R11 timeout", 0, 1);
            return;
        end
        g_fault = res_fault; g_pa = res_paddr;
        g_r = res_perm_r; g_w = res_perm_w; g_x = res_perm_x;
        if (hold) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(res_valid && res_paddr == g_pa && res_fault == g_fault && !req_ready,
                    "R11 hold", {res_valid, req_ready, res_fault}, {1'b1, 1'b0, g_fault});
            end
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        if (hold) chk(!res_valid && req_ready, "R11 release", {res_valid, req_ready}, 2'b01);
    endtask

    // leaf rules applied arithmetically
    task automatic ref_leaf(input logic [63:0] p, input int lvl, input logic [1:0] acc, input bit sm,
                            input bit sum, input bit mxr, output bit f, output logic [55:0] pa,
                            output bit r, output bit w, output bit x, output logic [63:0] np);
        bit v, pr, pw, px, pu, pd;
        logic [43:0] ppn, msk;
        v = p[0]; pr = p[1]; pw = p[2]; px = p[3]; pu = p[4]; pd = p[7];
        ppn = p[53:10];
        msk = (44'd1 << (lvl * 9)) - 44'd1;
        f = 0;
        if (!v) f = 1;
        else if (!pr && !pw && !px) f = 1;
        else if (pw && !pr) f = 1;
        else if (pu && sm && (!sum || acc == 2)) f = 1;
        else if (!pu && !sm) f = 1;
        else if ((ppn & msk) != 0) f = 1;
        else if (acc == 0 && !(pr || (px && mxr))) f = 1;
        else if (acc == 1 && !pw) f = 1;
        else if (acc == 2 && !px) f = 1;
        pa = {ppn | ({17'd0, VPN} & msk), 12'd0};
        r = pr || (px && mxr); x = px; w = pw && (acc == 1 || pd);
        np = p | 64'h40 | (acc == 1 ? 64'h80 : 64'h0);
    endtask

    task automatic check_walk(input logic [63:0] p, input int lvl, input int addr_w, input logic [1:0] acc,
                              input bit sm, input bit sum, input bit mxr, input int exp_rd);
        bit ef, er, ew, ex;
        logic [55:0] epa;
        logic [63:0] enp;
        int ecas;
        ref_leaf(p, lvl, acc, sm, sum, mxr, ef, epa, er, ew, ex, enp);
        mem[addr_w] = p;
        walk(acc, sm, sum, mxr, 0);
        if (g_to) return;
        ecas = (!ef && enp != p) ? 1 : 0;
        chk(g_fault == ef, "R3 R4 R5 R6 fault", g_fault, ef);
        if (!ef) begin
            chk(g_pa == epa, "R7 paddr", g_pa, epa);
            chk({g_r, g_w, g_x} == {er, ew, ex}, "R7 perms", {g_r, g_w, g_x}, {er, ew, ex});
            chk(mem[addr_w] == (ecas ? enp : p), "R8 memory", mem[addr_w], ecas ? enp : p);
        end
        chk(rd_cnt == exp_rd, "R2 reads", rd_cnt, exp_rd);
        chk(cas_cnt == ecas, "R8 cas count", cas_cnt, ecas);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !res_valid && !mem_req_valid, "R1 reset",
            {req_ready, res_valid, mem_req_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !res_valid && !mem_req_valid, "R1 idle",
            {req_ready, res_valid, mem_req_valid}, 3'b100);

        // level-0 sweep over flags, privilege, controls and access kinds
        tables();
        for (int fl = 0; fl < 64; fl++) begin
            for (int mode = 0; mode < 8; mode++) begin
                for (int a = 0; a < 3; a++) begin
                    logic [7:0] b;
                    b = {fl[5], fl[4], 1'b0, fl[3], fl[2], fl[1], fl[0], 1'b1};
                    check_walk(mk(44'h123, b), 0, widx(3, 7), 2'(a), mode[0], mode[1], mode[2], 3);
                end
            end
        end

        // R5: superpages at level 2 and level 1
        tables();
        check_walk(mk(44'd1 << 18, 8'hDB), 2, widx(1, 3), 2'd0, 1'b0, 1'b0, 1'b0, 1);
        check_walk(mk((44'd1 << 18) | 44'd1, 8'hDB), 2, widx(1, 3), 2'd0, 1'b0, 1'b0, 1'b0, 1);
        check_walk(mk((44'd1 << 18) | (44'd1 << 17), 8'hCB), 2, widx(1, 3), 2'd1, 1'b1, 1'b0, 1'b0, 1);
        tables();
        check_walk(mk(44'h400, 8'hCF), 1, widx(2, 5), 2'd2, 1'b1, 1'b0, 1'b0, 2);
        check_walk(mk(44'h401, 8'hCF), 1, widx(2, 5), 2'd2, 1'b1, 1'b0, 1'b0, 2);
        check_walk(mk(44'h500, 8'hCB), 1, widx(2, 5), 2'd1, 1'b1, 1'b0, 1'b0, 2);

        // R3: invalid entry at level 1 stops after two reads
        tables();
        mem[widx(2, 5)] = '0;
        walk(2'd0, 1'b1, 1'b0, 1'b0, 1);
        chk(g_fault == 1'b1, "R3 invalid mid-level", g_fault, 1);
        chk(rd_cnt == 2, "R3 reads", rd_cnt, 2);

        // R10: access error on the level-1 read
        tables();
        mem[widx(1, 3)] = mk(44'h10, 8'h01);
        walk(2'd0, 1'b1, 1'b0, 1'b0, 0);
        chk(g_fault == 1'b1, "R10 error", g_fault, 1);
        chk(rd_cnt == 2, "R10 reads", rd_cnt, 2);

        // R10: leaf in a non-writable page needing an update
        tables();
        mem[widx(2, 5)] = mk(44'd7, 8'h01);
        mem[widx(7, 7)] = mk(44'h77, 8'h07);
        walk(2'd1, 1'b1, 1'b0, 1'b0, 0);
        chk(g_fault == 1'b1, "R10 nowr fault", g_fault, 1);
        chk(cas_cnt == 1, "R10 nowr cas", cas_cnt, 1);
        chk(mem[widx(7, 7)] == mk(44'h77, 8'h07), "R10 unchanged", mem[widx(7, 7)], mk(44'h77, 8'h07));

        // R8: same page, nothing to update, succeeds without a swap
        mem[widx(7, 7)] = mk(44'h77, 8'hC7);
        walk(2'd1, 1'b1, 1'b0, 1'b0, 1);
        chk(g_fault == 1'b0 && g_w, "R8 no-update ok", {g_fault, g_w}, 2'b01);
        chk(cas_cnt == 0, "R8 no swap", cas_cnt, 0);
        chk(g_pa == {44'h77, 12'd0}, "R7 paddr rom", g_pa, {44'h77, 12'd0});

        // R9: entry changed by another agent, walk restarts from root
        tables();
        mem[widx(3, 7)] = mk(44'h2AB, 8'h03);
        interfere = 1;
        walk(2'd0, 1'b1, 1'b0, 1'b0, 1);
        chk(g_fault == 1'b0, "R9 restart result", g_fault, 0);
        chk(rd_cnt == 6, "R9 reads", rd_cnt, 6);
        chk(cas_cnt == 2, "R9 swaps", cas_cnt, 2);
        chk(mem[widx(3, 7)] == mk(44'h2AB, 8'h63), "R9 memory", mem[widx(3, 7)], mk(44'h2AB, 8'h63));
        chk(g_pa == {44'h2AB, 12'd0}, "R9 paddr", g_pa, {44'h2AB, 12'd0});

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule